// File: doc/BRIEF.md
# Address Translation Mode Selector

This block sits at the front of a memory-management unit. It decides how a virtual address is translated, and it sends only the addresses that need a page-table lookup on to the TLB path. When the direct-address mode bit is set and the paging bit is clear, the address goes straight through, cut to the physical width, with full access rights.

In any other mode the block compares the address with four direct-map window registers, in a fixed priority order, and only windows enabled for the current privilege take part. The first window that hits gives the physical address, with full rights. In 64-bit mode the physical address is the virtual address cut to the virtual width. In 32-bit mode the upper segment is replaced by a field taken from the window. An address that hits no window must be in canonical form. If it is, it becomes a TLB request. If it is not, the result is a bad-address outcome.

The result is registered, so it appears one clock after the request.

Top module: `addr_xlat_sel`

## Requirements
- R1: When `daBit`=1 and `pgBit`=0, the result has kind MAP (2'b00), `outPaddr` = `vaddr[47:0]` and `outPerm` = 3'b111, whatever the window registers hold. Every other combination of `daBit` and `pgBit` takes the window, canonical and TLB path of R2 to R9.
- R2: A window takes part only if its enable bits match the current privilege. In kernel mode (`userMode`=0) the window's bit 0 must be set. In user mode (`userMode`=1) the window's bit 3 must be set.
- R3: In 64-bit mode (`wide64`=1) a window matches when its bits [63:60] equal `vaddr[63:60]`.
- R4: When several windows hit, the one with the lowest index wins. Window k occupies `winRegs[64k+63:64k]`.
- R5: On a window hit in 64-bit mode, `outPaddr` = `vaddr[47:0]`.
- R6: In 32-bit mode (`wide64`=0) a window matches when its bits [31:29] equal `vaddr[31:29]`. On a hit, `outPaddr` = {16'b0, window bits [27:25], `vaddr[28:0]`}.
- R7: A window hit gives kind MAP and `outPerm` = 3'b111. The permission bits are read (bit 2), write (bit 1) and execute (bit 0).
- R8: When no window hits and `vaddr[63:48]` is neither all zeros nor all ones, the result has kind BAD (2'b10), `outPaddr` = 0 and `outPerm` = 0.
- R9: When no window hits and `vaddr[63:48]` is all zeros or all ones, the result has kind TLB (2'b01), `outPaddr` = 0 and `outPerm` = 0.
- R10: A request taken while `inValid`=1 shows its result with `outValid`=1 exactly one clock later. After a cycle with `inValid`=0, `outValid` is 0.
- R11: While reset is held, `outValid`, `outKind`, `outPaddr` and `outPerm` are all zero.
- R12: A window hit wins over the canonical check, so a non-canonical address that hits a window is mapped and not reported BAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| vaddr | input | 64 | Virtual address |
| daBit | input | 1 | Direct-address mode bit |
| pgBit | input | 1 | Paging-enable bit |
| userMode | input | 1 | 1 = user privilege, 0 = kernel |
| wide64 | input | 1 | 1 = 64-bit address mode, 0 = 32-bit |
| winRegs | input | 256 | Four window registers, window k in bits [64k+63:64k] |
| outValid | output | 1 | Result valid |
| outKind | output | 2 | 00 MAP, 01 TLB, 10 BAD |
| outPaddr | output | 48 | Physical address (MAP only, else 0) |
| outPerm | output | 3 | Read/write/execute rights |

## Verification
The bench sets up windows that could hit in direct mode, so a design that does not bypass them would remap the address. It uses a user-mode request against a window enabled only through bit 0, so a design that tests the wrong privilege bit would report a hit instead of a TLB request. It makes two windows hit at once, so a design with the wrong priority would return the other window's segment. It gives 32-bit and 64-bit hits different remap results, so a design that mixes up the two remap rules would return the wrong address. It uses a non-canonical address that hits a window, so a design that runs the canonical check first would report BAD. Random requests against a behavioural model check the remaining combinations.

// File: rtl/addrsel_pkg.sv
package addrsel_pkg;
  localparam int WIN_CNT   = 4;
  localparam int WIN_IDX_W = (WIN_CNT > 1) ? $clog2(WIN_CNT) : 1;

  typedef enum logic [1:0] {
    KIND_MAP = 2'b00,
    KIND_TLB = 2'b01,
    KIND_BAD = 2'b10
  } xlatKind_e;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;

  // strobes from control to datapath; exactly one take* is set per request
  typedef struct packed {
    logic                 takeDirect;
    logic                 takeWin;
    logic                 takeTlb;
    logic                 takeBad;
    logic [WIN_IDX_W-1:0] winIdx;
  } selStrobe_t;
endpackage

// File: rtl/addrsel_winmatch.sv
module addrsel_winmatch
  import addrsel_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int NUM_WIN   = WIN_CNT,
  parameter int SEG64_LSB = 60,
  parameter int SEG32_LSB = 29,
  parameter int KERN_BIT  = 0,
  parameter int USER_BIT  = 3
) (
  input  logic [ADDR_W-1:0]         vaddr,
  input  logic                      userMode,
  input  logic                      wide64,
  input  logic [NUM_WIN*ADDR_W-1:0] winFlat,
  output logic [NUM_WIN-1:0]        hitVec
);
  localparam int WORD32_W = 32;

  logic [ADDR_W-1:0] privMask;

  always_comb begin
    privMask           = '0;
    privMask[KERN_BIT] = ~userMode;
    privMask[USER_BIT] = userMode;
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    logic [ADDR_W-1:0] winReg;
    logic              privOk;
    logic              seg64Eq;
    logic              seg32Eq;

    assign winReg  = winFlat[g*ADDR_W +: ADDR_W];
    assign privOk  = |(winReg & privMask);
    assign seg64Eq = winReg[ADDR_W-1:SEG64_LSB] == vaddr[ADDR_W-1:SEG64_LSB];
    assign seg32Eq = winReg[WORD32_W-1:SEG32_LSB] == vaddr[WORD32_W-1:SEG32_LSB];
    assign hitVec[g] = privOk && (wide64 ? seg64Eq : seg32Eq);
  end
endmodule

// File: rtl/addrsel_ctrl.sv
module addrsel_ctrl
  import addrsel_pkg::*;
#(
  parameter int NUM_WIN = WIN_CNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               daBit,
  input  logic               pgBit,
  input  logic [NUM_WIN-1:0] hitVec,
  input  logic               canonOk,
  output selStrobe_t         strobe
);
  logic found;

  always_comb begin
    strobe = '0;
    found  = 1'b0;
    if (daBit && !pgBit) begin
      strobe.takeDirect = 1'b1;
    end else begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (!found && hitVec[i]) begin
          found         = 1'b1;
          strobe.winIdx = WIN_IDX_W'(i);
        end
      end
      if (found)        strobe.takeWin = 1'b1;
      else if (canonOk) strobe.takeTlb = 1'b1;
      else              strobe.takeBad = 1'b1;
    end
  end

  // R4: the chosen window hits and no lower-index window hits
  assert_lowest_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeWin |-> (hitVec[strobe.winIdx] &&
      ((hitVec & ((NUM_WIN'(1) << strobe.winIdx) - NUM_WIN'(1))) == '0)));

  // R12: any window hit outside direct mode is taken, whatever the canonical check says
  assert_win_before_canon_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!(daBit && !pgBit) && (hitVec != '0)) |-> strobe.takeWin);

  assert_one_path_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({strobe.takeDirect, strobe.takeWin, strobe.takeTlb, strobe.takeBad}));
endmodule

// File: rtl/addrsel_dp.sv
module addrsel_dp
  import addrsel_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VA_W       = 48,
  parameter int PA_W       = 48,
  parameter int NUM_WIN    = WIN_CNT,
  parameter int SEG32_LSB  = 29,
  parameter int PSEG32_LSB = 25
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [ADDR_W-1:0]         vaddr,
  input  logic                      wide64,
  input  logic [NUM_WIN*ADDR_W-1:0] winFlat,
  input  selStrobe_t                strobe,
  output logic                      canonOk,
  output logic                      outValid,
  output logic [1:0]                outKind,
  output logic [PA_W-1:0]           outPaddr,
  output logic [2:0]                outPerm
);
  localparam int WORD32_W = 32;
  localparam int SEG32_W  = WORD32_W - SEG32_LSB;
  localparam int HIGH_W   = ADDR_W - VA_W;

  logic [ADDR_W-1:0]   winArr [NUM_WIN];
  logic [ADDR_W-1:0]   selWin;
  logic [HIGH_W-1:0]   highBits;
  logic [WORD32_W-1:0] pa32;
  logic [PA_W-1:0]     winPa;
  logic [PA_W-1:0]     paNext;
  logic [1:0]          kindNext;
  logic [2:0]          permNext;

  for (genvar g = 0; g < NUM_WIN; g++) begin : gUnpack
    assign winArr[g] = winFlat[g*ADDR_W +: ADDR_W];
  end

  assign selWin   = winArr[strobe.winIdx];
  assign highBits = vaddr[ADDR_W-1:VA_W];
  assign canonOk  = (&highBits) || !(|highBits);
  assign pa32     = {selWin[PSEG32_LSB +: SEG32_W], vaddr[SEG32_LSB-1:0]};
  assign winPa    = wide64 ? PA_W'(vaddr[VA_W-1:0]) : PA_W'(pa32);

  always_comb begin
    paNext   = '0;
    permNext = PERM_NONE;
    kindNext = KIND_MAP;
    if (strobe.takeDirect) begin
      paNext   = vaddr[PA_W-1:0];
      permNext = PERM_ALL;
    end else if (strobe.takeWin) begin
      paNext   = winPa;
      permNext = PERM_ALL;
    end else if (strobe.takeTlb) begin
      kindNext = KIND_TLB;
    end else begin
      kindNext = KIND_BAD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outKind  <= KIND_MAP;
      outPaddr <= '0;
      outPerm  <= PERM_NONE;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outKind  <= kindNext;
        outPaddr <= paNext;
        outPerm  <= permNext;
      end
    end
  end

  assert_direct_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.takeDirect) |=>
      (outKind == KIND_MAP && outPerm == PERM_ALL && outPaddr == $past(vaddr[PA_W-1:0])));

  assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_map_perm_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_MAP) |-> outPerm == PERM_ALL);

  assert_bad_noncanon_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.takeBad) |=>
      (outKind == KIND_BAD && outPaddr == '0 && outPerm == PERM_NONE &&
       !($past(&vaddr[ADDR_W-1:VA_W]) || !$past(|vaddr[ADDR_W-1:VA_W]))));

  assert_tlb_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_TLB) |-> (outPaddr == '0 && outPerm == PERM_NONE));

  assert_kind_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    outKind != 2'b11);
endmodule

// File: rtl/addr_xlat_sel.sv
module addr_xlat_sel
  import addrsel_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VA_W       = 48,
  parameter int PA_W       = 48,
  parameter int NUM_WIN    = WIN_CNT,
  parameter int SEG64_LSB  = 60,
  parameter int SEG32_LSB  = 29,
  parameter int PSEG32_LSB = 25,
  parameter int KERN_BIT   = 0,
  parameter int USER_BIT   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [ADDR_W-1:0]         vaddr,
  input  logic                      daBit,
  input  logic                      pgBit,
  input  logic                      userMode,
  input  logic                      wide64,
  input  logic [NUM_WIN*ADDR_W-1:0] winRegs,
  output logic                      outValid,
  output logic [1:0]                outKind,
  output logic [PA_W-1:0]           outPaddr,
  output logic [2:0]                outPerm
);
  logic [NUM_WIN-1:0] hitVec;
  logic               canonOk;
  selStrobe_t         strobe;

  addrsel_winmatch #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .SEG64_LSB(SEG64_LSB),
    .SEG32_LSB(SEG32_LSB), .KERN_BIT(KERN_BIT), .USER_BIT(USER_BIT)
  ) u_match (
    .vaddr(vaddr), .userMode(userMode), .wide64(wide64),
    .winFlat(winRegs), .hitVec(hitVec)
  );

  addrsel_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .daBit(daBit), .pgBit(pgBit),
    .hitVec(hitVec), .canonOk(canonOk), .strobe(strobe)
  );

  addrsel_dp #(
    .ADDR_W(ADDR_W), .VA_W(VA_W), .PA_W(PA_W), .NUM_WIN(NUM_WIN),
    .SEG32_LSB(SEG32_LSB), .PSEG32_LSB(PSEG32_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .vaddr(vaddr),
    .wide64(wide64), .winFlat(winRegs), .strobe(strobe),
    .canonOk(canonOk), .outValid(outValid), .outKind(outKind),
    .outPaddr(outPaddr), .outPerm(outPerm)
  );
endmodule

// File: tb/addr_xlat_sel_tb.sv
module addr_xlat_sel_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [63:0]  vaddr = '0;
  logic         daBit = 1'b0, pgBit = 1'b1, userMode = 1'b0, wide64 = 1'b1;
  logic [63:0]  win [4];
  logic [255:0] winRegs;
  logic         outValid;
  logic [1:0]   outKind;
  logic [47:0]  outPaddr;
  logic [2:0]   outPerm;

  int    nCmp = 0, nBad = 0;
  bit    pend = 0, done = 0;
  logic [1:0]  eKind;
  logic [47:0] ePa;
  logic [2:0]  ePerm;
  string eTag;

  always #2 clk = ~clk;

  assign winRegs = {win[3], win[2], win[1], win[0]};

  addr_xlat_sel u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .vaddr(vaddr),
    .daBit(daBit), .pgBit(pgBit), .userMode(userMode), .wide64(wide64),
    .winRegs(winRegs), .outValid(outValid), .outKind(outKind),
    .outPaddr(outPaddr), .outPerm(outPerm)
  );

  function automatic void refModel(input logic [63:0] va, input logic da, pg, usr, w64,
                                   output logic [1:0] k, output logic [47:0] pa,
                                   output logic [2:0] pm, output string tg);
    logic [3:0] pmask;
    pmask = usr ? 4'b1000 : 4'b0001;
    k = 2'b00; pa = '0; pm = 3'b000;
    if (da && !pg) begin
      pa = va[47:0]; pm = 3'b111; tg = "R1";
      return;
    end
    for (int i = 0; i < 4; i++) begin
      bit segEq;
      segEq = w64 ? (win[i][63:60] == va[63:60]) : (win[i][31:29] == va[31:29]);
      if (((win[i][3:0] & pmask) != 0) && segEq) begin
        pm = 3'b111;
        pa = w64 ? va[47:0] : {16'h0, win[i][27:25], va[28:0]};
        tg = w64 ? "R5" : "R6";
        return;
      end
    end
    if (va[63:48] == 16'h0000 || va[63:48] == 16'hFFFF) begin
      k = 2'b01; tg = "R9";
    end else begin
      k = 2'b10; tg = "R8";
    end
  endfunction

  task automatic checkOut();
    bit bad;
    bad = 0;
    nCmp++;
    if (pend) begin
      if (outValid !== 1'b1) begin
        $display("FAIL R10 outValid actual=%b expected=1", outValid); bad = 1;
      end
      if (outKind !== eKind) begin
        $display("FAIL %s kind actual=%b expected=%b", eTag, outKind, eKind); bad = 1;
      end
      if (outPaddr !== ePa) begin
        $display("FAIL %s paddr actual=%h expected=%h", eTag, outPaddr, ePa); bad = 1;
      end
      if (outPerm !== ePerm) begin
        $display("FAIL %s perm actual=%b expected=%b", eTag, outPerm, ePerm); bad = 1;
      end
    end else if (outValid !== 1'b0) begin
      $display("FAIL R10 idle outValid actual=%b expected=0", outValid); bad = 1;
    end
    if (bad) nBad++;
  endtask

  // drive at the falling edge, the result is checked one falling edge later
  task automatic step(input logic v, input logic [63:0] va, input logic da, pg, usr, w64,
                      input string tag);
    string mt;
    @(negedge clk);
    checkOut();
    inValid = v; vaddr = va; daBit = da; pgBit = pg; userMode = usr; wide64 = w64;
    if (v) begin
      refModel(va, da, pg, usr, w64, eKind, ePa, ePerm, mt);
      eTag = (tag == "") ? mt : tag;
    end
    pend = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nBad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) win[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nCmp++;
    if (outValid !== 1'b0 || outKind !== 2'b00 || outPaddr !== '0 || outPerm !== 3'b000) begin
      nBad++;
      $display("FAIL R11 reset actual=%b/%b/%h/%b expected=0/00/0/000",
               outValid, outKind, outPaddr, outPerm);
    end
    rstN = 1'b1;
    step(0, '0, 0, 1, 0, 1, "R11");

    // direct mode ignores a window that would hit
    win[0] = 64'hA000_0000_0000_0009;
    step(1, 64'hA123_4567_89AB_CDEF, 1, 0, 0, 1, "R1");
    // da=1 pg=1 is not direct: window 0 hits, non-canonical but mapped
    step(1, 64'hA123_4567_89AB_CDEF, 1, 1, 0, 1, "R12");
    // kernel hit through bit 0
    step(1, 64'hA000_1234_5678_9ABC, 0, 1, 0, 1, "R2");
    // user mode against a bit0-only window: no hit, canonical -> TLB
    win[0] = 64'h0000_0000_0000_0001;
    step(1, 64'h0000_7FFF_0000_1000, 0, 1, 1, 1, "R2");
    // user hit through bit 3
    win[0] = 64'h0000_0000_0000_0008;
    step(1, 64'h0000_7FFF_0000_1000, 0, 1, 1, 1, "R7");
    // segment mismatch -> canonical upper ones -> TLB
    win[0] = 64'h9000_0000_0000_0001;
    step(1, 64'hFFFF_8000_0000_0040, 0, 1, 0, 1, "R3");
    // segment mismatch, non-canonical -> BAD
    step(1, 64'h1234_0000_0000_0040, 0, 1, 0, 1, "R8");
    // two windows hit in 32-bit mode; the lower index supplies the segment
    win[1] = 64'h0000_0000_A600_0001;
    win[2] = 64'h0000_0000_A200_0001;
    step(1, 64'h0000_0000_B234_5678, 0, 1, 0, 0, "R4");
    win[1] = '0;
    step(1, 64'h0000_0000_B234_5678, 0, 1, 0, 0, "R6");
    // 64-bit remap keeps the low virtual bits
    win[3] = 64'hC000_0000_0000_0008;
    step(1, 64'hC000_ABCD_1234_5678, 0, 1, 1, 1, "R5");
    step(0, '0, 0, 1, 0, 1, "R10");

    for (int n = 0; n < 400; n++) begin
      logic [63:0] va;
      for (int i = 0; i < 4; i++) begin
        win[i] = {$urandom, $urandom};
        win[i][63:62] = 2'b00;
        win[i][31:30] = 2'b00;
      end
      va = {$urandom, $urandom};
      case (n % 4)
        0: va[63:48] = 16'h0000;
        1: va[63:48] = 16'hFFFF;
        2: va[63:62] = 2'b00;
        default: ;
      endcase
      if (n % 3 == 0) va[31:30] = 2'b00;
      step(($urandom % 5) != 0, va, $urandom, $urandom, $urandom, $urandom, "");
    end
    step(0, '0, 0, 1, 0, 1, "R10");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule